// File: doc/BRIEF.md
# I2C Clock Phase Timer

This block times the serial clock of an I2C master. While the bit engine holds `run` high, it drives SCL through repeated low and high phases. It gives the bit engine three one-cycle strobes: one when the clock falls, one in the middle of the low phase (the point to change SDA) and one in the middle of the high phase (the point to sample SDA). When `run` is low, SCL is released and the phase counter is held at zero.

Two timing modes are available. In symmetric mode a single 12-bit divider counts quarter periods, so each phase lasts two divider units. In split mode the divider sets the high phase alone and a second 12-bit count sets the low phase, which allows an asymmetric duty such as 40/60. The 12-bit divider arrives as a 10-bit base field plus a 2-bit extension that forms its top bits.

The line is sensed through a reset-to-high synchronizer of `SYNC_STAGES` flops. The high phase counts only while the sensed line is high, so a slow rise or an input filter makes the high phase longer. The low phase does not end until the sensed line has actually gone low.

Top module: `i2c_scl_timer`

## Requirements
- R1: The divider value is `{div_ext, div_base}`, with `div_ext` as bits 11:10 and `div_base` as bits 9:0.
- R2: With `split_en` = 0, both the high count and the low count are 2·D cycles, where D is the divider. `low_count` has no effect in this mode.
- R3: With `split_en` = 1, the high count is D cycles and the low count is `low_count` cycles.
- R4: A divider or low count of zero is treated as one.
- R5: The high count advances only on cycles where the synchronized line is high. SCL is therefore driven high for (high count + SYNC_STAGES + external rise delay) cycles.
- R6: A low phase ends only after its count has elapsed and the synchronized line reads low. It lasts max(low count, SYNC_STAGES + 1 + external delay) cycles.
- R7: `stb_fall` pulses exactly once per low phase, on its first cycle, and only when SCL falls.
- R8: `stb_mid_low` pulses once per low phase, on cycle index floor(low count / 2), counting the first low cycle as 0.
- R9: `stb_mid_high` pulses once per high phase, on cycle index SYNC_STAGES + external delay + floor(high count / 2), and only while the sensed line is high.
- R10: One cycle after `run` is seen low, SCL is released and all strobes are low. A later `run` always begins with a fresh low phase.
- R11: While `rst` is high, SCL is released and no strobe fires, even if `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Clock request from the bit engine |
| div_base | input | 10 | Divider bits 9:0 |
| div_ext | input | 2 | Divider bits 11:10 |
| low_count | input | 12 | Low-phase count, used in split mode |
| split_en | input | 1 | 1 = separate high and low counts; 0 = symmetric quarter-period mode |
| scl_in | input | 1 | Sensed SCL line |
| scl_drive | output | 1 | 1 = release SCL, 0 = pull SCL low |
| stb_fall | output | 1 | Strobe on the first cycle of each low phase |
| stb_mid_low | output | 1 | Strobe in the middle of the low phase |
| stb_mid_high | output | 1 | Strobe in the middle of the high phase |

## Verification
SCL falls on the first clock edge that sees `run`. The sensed line follows SCL after SYNC_STAGES + 1 edges plus any delay the bench inserts on the return path. For that reason every expected high length, low length and mid-high strobe index is computed with these latencies added to the programmed counts. The scoreboard measures phase lengths and strobe positions at falling clock edges, as cycle indices counted from the start of each phase. After `run` drops, the idle checks wait one rising edge for the state register to clear before they sample.

// File: rtl/i2c_scl_timer_pkg.sv
package i2c_scl_timer_pkg;

    localparam int DIV_W  = 12;
    localparam int BASE_W = 10;
    localparam int EXT_W  = DIV_W - BASE_W;
    localparam int CNT_W  = DIV_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] high_len;
        logic [CNT_W-1:0] low_len;
    } phase_len_t;

    // A zero count would never expire, so it is lifted to one.
    function automatic logic [DIV_W-1:0] nz_count(input logic [DIV_W-1:0] v);
        return (v == '0) ? DIV_W'(1) : v;
    endfunction

endpackage

// File: rtl/scl_len_calc.sv
module scl_len_calc
    import i2c_scl_timer_pkg::*;
(
    input  logic [BASE_W-1:0] div_base,
    input  logic [EXT_W-1:0]  div_ext,
    input  logic [DIV_W-1:0]  low_count,
    input  logic              split_en,
    output phase_len_t        lens
);
    logic [DIV_W-1:0] div_full;
    logic [DIV_W-1:0] div_nz;
    logic [DIV_W-1:0] low_nz;

    assign div_full = {div_ext, div_base};
    assign div_nz   = nz_count(div_full);
    assign low_nz   = nz_count(low_count);

    always_comb begin
        if (split_en) begin
            lens.high_len = {1'b0, div_nz};
            lens.low_len  = {1'b0, low_nz};
        end else begin
            // two quarter-period units per phase
            lens.high_len = {div_nz, 1'b0};
            lens.low_len  = {div_nz, 1'b0};
        end
    end
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES == 0) begin : g_direct
            assign dout = din;
        end else begin : g_chain
            for (genvar i = 0; i < STAGES; i++) begin : g_st
                logic q;
                if (i == 0) begin : g_first
                    always_ff @(posedge clk) begin
                        if (rst) q <= 1'b1;
                        else     q <= din;
                    end
                end else begin : g_next
                    always_ff @(posedge clk) begin
                        if (rst) q <= 1'b1;
                        else     q <= g_st[i-1].q;
                    end
                end
            end
            assign dout = g_st[STAGES-1].q;
        end
    endgenerate
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import i2c_scl_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sensed,
    input  phase_len_t       lens,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    phase <= PH_LOW;
                    cnt   <= '0;
                end
                PH_LOW: begin
                    if ((cnt >= lens.low_len - ONE) && !sensed) begin
                        phase <= PH_HIGH;
                        cnt   <= '0;
                    end else if (cnt != '1) begin
                        cnt <= cnt + ONE;
                    end
                end
                PH_HIGH: begin
                    if (sensed) begin
                        if (cnt == lens.high_len - ONE) begin
                            phase <= PH_LOW;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec
    import i2c_scl_timer_pkg::*;
(
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sensed,
    input  phase_len_t       lens,
    output logic             stb_fall,
    output logic             stb_mid_low,
    output logic             stb_mid_high
);
    logic in_low;
    logic in_high;

    assign in_low       = (phase == PH_LOW);
    assign in_high      = (phase == PH_HIGH);
    assign stb_fall     = in_low && (cnt == '0);
    assign stb_mid_low  = in_low && (cnt == (lens.low_len >> 1));
    assign stb_mid_high = in_high && sensed && (cnt == (lens.high_len >> 1));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_scl_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [BASE_W-1:0] div_base,
    input  logic [EXT_W-1:0]  div_ext,
    input  logic [DIV_W-1:0]  low_count,
    input  logic              split_en,
    input  logic              scl_in,
    output logic              scl_drive,
    output logic              stb_fall,
    output logic              stb_mid_low,
    output logic              stb_mid_high
);
    phase_len_t       lens;
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             scl_sensed;

    scl_len_calc u_len (
        .div_base  (div_base),
        .div_ext   (div_ext),
        .low_count (low_count),
        .split_en  (split_en),
        .lens      (lens)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (scl_in),
        .dout (scl_sensed)
    );

    scl_phase_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .sensed (scl_sensed),
        .lens   (lens),
        .phase  (phase),
        .cnt    (cnt)
    );

    scl_strobe_dec u_dec (
        .phase        (phase),
        .cnt          (cnt),
        .sensed       (scl_sensed),
        .lens         (lens),
        .stb_fall     (stb_fall),
        .stb_mid_low  (stb_mid_low),
        .stb_mid_high (stb_mid_high)
    );

    assign scl_drive = (phase != PH_LOW);
endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic scl_sensed,
    input logic scl_drive,
    input logic stb_fall,
    input logic stb_mid_low,
    input logic stb_mid_high
);
    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (scl_drive && !stb_fall && !stb_mid_low && !stb_mid_high));

    // R7
    fall_has_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(scl_drive) |-> stb_fall);

    // R7
    strobe_only_at_fall_chk: assert property (@(posedge clk) disable iff (rst)
        stb_fall |-> $fell(scl_drive));

    // R8
    mid_low_level_chk: assert property (@(posedge clk) disable iff (rst)
        stb_mid_low |-> !scl_drive);

    // R9
    mid_high_level_chk: assert property (@(posedge clk) disable iff (rst)
        stb_mid_high |-> (scl_drive && scl_sensed));

    // R6
    rise_after_low_seen_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(scl_drive) && $past(run)) |-> !$past(scl_sensed));
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .scl_sensed   (scl_sensed),
    .scl_drive    (scl_drive),
    .stb_fall     (stb_fall),
    .stb_mid_low  (stb_mid_low),
    .stb_mid_high (stb_mid_high)
);

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        run;
    logic [9:0]  div_base;
    logic [1:0]  div_ext;
    logic [11:0] low_count;
    logic        split_en;
    logic        scl_in;
    logic        scl_drive, stb_fall, stb_mid_low, stb_mid_high;

    always #2 clk = ~clk;   // 250 MHz

    logic [7:0] dly = 8'hFF;
    int         xdel = 0;
    always @(posedge clk) dly <= {dly[6:0], scl_drive};
    always_comb scl_in = (xdel == 0) ? scl_drive : dly[xdel-1];

    i2c_scl_timer #(.SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst(rst), .run(run), .div_base(div_base), .div_ext(div_ext),
        .low_count(low_count), .split_en(split_en), .scl_in(scl_in),
        .scl_drive(scl_drive), .stb_fall(stb_fall), .stb_mid_low(stb_mid_low),
        .stb_mid_high(stb_mid_high)
    );

    typedef struct { int hi; int lo; int mlo; int mhi; } exp_t;
    exp_t  q[$];
    int    n_chk = 0, n_fail = 0, periods_done = 0;
    string cur_tag = "R11";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    int mph = 0;   // 0 idle, 1 low, 2 high
    int idx = 0, lo_meas = 0;
    int f_n = 0, f_pos = -1, ml_n = 0, ml_pos = -1, mh_n = 0, mh_pos = -1;

    always @(negedge clk) begin
        if (rst || !run) begin
            mph = 0;
        end else begin
            if (mph == 0) begin
                if (!scl_drive) begin
                    mph = 1; idx = 0; f_n = 0; ml_n = 0; f_pos = -1; ml_pos = -1;
                end
            end else if (mph == 1) begin
                if (!scl_drive) idx++;
                else begin
                    lo_meas = idx + 1; mph = 2; idx = 0; mh_n = 0; mh_pos = -1;
                end
            end else begin
                if (scl_drive) idx++;
                else begin
                    exp_t e;
                    if (q.size() == 0) begin
                        check(1'b0, {cur_tag, " scoreboard empty"}, 0, 1);
                    end else begin
                        e = q.pop_front();
                        check(idx + 1 == e.hi, {cur_tag, " R5 high length"}, idx + 1, e.hi);
                        check(lo_meas == e.lo, {cur_tag, " R6 low length"}, lo_meas, e.lo);
                        check(f_n == 1 && f_pos == 0 && ml_n == 1 && mh_n == 1,
                              {cur_tag, " R7 strobe counts/fall pos"}, f_n*100 + ml_n*10 + mh_n, 111);
                        check(ml_pos == e.mlo, {cur_tag, " R8 mid-low index"}, ml_pos, e.mlo);
                        check(mh_pos == e.mhi, {cur_tag, " R9 mid-high index"}, mh_pos, e.mhi);
                    end
                    periods_done++;
                    mph = 1; idx = 0; f_n = 0; ml_n = 0; f_pos = -1; ml_pos = -1;
                end
            end
            if (mph == 1) begin
                if (stb_fall)    begin f_n++;  f_pos  = idx; end
                if (stb_mid_low) begin ml_n++; ml_pos = idx; end
            end else if (mph == 2) begin
                if (stb_mid_high) begin mh_n++; mh_pos = idx; end
            end
        end
    end

    // ---------------- driver ----------------
    function automatic exp_t calc(input int base, input int ext, input int low,
                                  input bit split, input int x);
        exp_t e;
        int d, h, l;
        d = ext * 1024 + base;                 // R1
        if (d == 0) d = 1;                     // R4
        if (low == 0) low = 1;
        if (split) begin h = d; l = low; end   // R3
        else begin h = 2 * d; l = 2 * d; end   // R2
        e.hi  = h + SYNC + x;
        e.lo  = (l > SYNC + 1 + x) ? l : SYNC + 1 + x;
        e.mlo = l / 2;
        e.mhi = SYNC + x + h / 2;
        return e;
    endfunction

    task automatic idle_checks();
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(scl_drive == 1'b1, "R10 released after run low", scl_drive, 1);
            check({stb_fall, stb_mid_low, stb_mid_high} == 3'b000, "R10 no strobes", 
                  {stb_fall, stb_mid_low, stb_mid_high}, 0);
        end
    endtask

    task automatic run_case(input string tag, input int base, input int ext, input int low,
                            input bit split, input int x, input int nper);
        int target;
        @(posedge clk); #1;
        cur_tag   = tag;
        div_base  = base[9:0];
        div_ext   = ext[1:0];
        low_count = low[11:0];
        split_en  = split;
        xdel      = x;
        repeat (10) @(posedge clk);
        #1;
        for (int i = 0; i < nper; i++) q.push_back(calc(base, ext, low, split, x));
        target = periods_done + nper;
        run = 1'b1;
        while (periods_done < target) @(posedge clk);
        #1;
        run = 1'b0;
        check(q.size() == 0, {tag, " all expected periods seen"}, q.size(), 0);
        idle_checks();
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        rst = 1'b1; run = 1'b1;   // run held high during reset on purpose
        div_base = 10'd3; div_ext = 2'd0; low_count = 12'd0; split_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(scl_drive == 1'b1, "R11 reset drive", scl_drive, 1);
            check({stb_fall, stb_mid_low, stb_mid_high} == 3'b000, "R11 reset strobes",
                  {stb_fall, stb_mid_low, stb_mid_high}, 0);
        end
        @(posedge clk); #1;
        run = 1'b0;
        rst = 1'b0;
        repeat (3) @(posedge clk);

        run_case("R2 symmetric d3",        3,  0,   0, 1'b0, 0, 3);
        run_case("R3 split 40/60",         4,  0,   6, 1'b1, 0, 3);
        run_case("R4 split zeros",         0,  0,   0, 1'b1, 0, 3);
        run_case("R4 symmetric zero",      0,  0,   0, 1'b0, 0, 3);
        run_case("R1 extension bits",      5,  1,   7, 1'b1, 0, 2);
        run_case("R2 low count ignored",   2,  0, 100, 1'b0, 0, 3);
        run_case("R5 slow rise",           5,  0,   8, 1'b1, 3, 3);
        run_case("R10 restart",            3,  0,   0, 1'b0, 0, 2);
        finish_up();
    end
endmodule